// File: doc/BRIEF.md
# Two-Cycle Constant Loader Sequencer

This block is the fetch and sequencing control of a small byte-wide core whose 16-bit instruction words sit in a synchronous program memory with a single read port. In the ordinary case it issues one instruction per cycle. The PC steps by one, and the live opcode and destination index of the fetched word pass straight through to the decoder and register write port.

One instruction, the load-constant, reads a byte of program memory as data. The memory has only one port, so the sequencer shares it over time. In the first cycle the next-fetch address is taken from the source register value instead of the PC. The PC holds, and an internal busy flag is set. The memory answers in the second cycle. The sequencer then outputs the high or low byte of that word, as selected by a flag captured in the first cycle. It forces a move opcode and replays the saved destination index, so the ordinary datapath writes the byte. The PC moves only after the second cycle. An interrupt in either cycle abandons the instruction so that it restarts from its first cycle.

The memory captures `pmem_addr_o` on each rising edge and presents that word on `instr_i` during the following cycle. `pc_o` is the address of the word on `instr_i`. Instruction fields are: opcode in bits [15:12], byte-select flag in bit 11, and destination index in bits [10:8].

Top module: `ldc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pmem_addr_o` is 0 and `dst_we_o` is 0. After reset, `pc_o` is 0 and the busy flag is clear.
- R2: For an opcode other than load-constant (4'hC), outside the second cycle: `opcode_o` and `dst_idx_o` are the word's fields, `dst_we_o` equals `cond_ok_i`, `pmem_addr_o` is `pc_o`+1, and the PC steps by one.
- R3: A load-constant with `cond_ok_i` high and no interrupt drives `pmem_addr_o` from `src_val_i`, holds `dst_we_o` low and keeps `pc_o` unchanged for the next cycle.
- R4: In the second cycle, `byte_o` is bits [15:8] of the word read if the captured bit 11 was 1, and bits [7:0] if it was 0. Outside the second cycle, `byte_o` is bits [7:0] of `instr_i`.
- R5: In the second cycle, `opcode_o` is the move code 4'h1 and `dst_idx_o` is the index captured in the first cycle. `dst_we_o` is 1 whatever `cond_ok_i` and the fields of the word read.
- R6: A load-constant with `cond_ok_i` low is a one-cycle no-op: no write, `pmem_addr_o` is `pc_o`+1, the PC steps by one, and the next cycle is an ordinary cycle.
- R7: The busy flag lasts exactly one cycle. In the second cycle `pmem_addr_o` is `pc_o`+1, and the PC has advanced by one in total after the two cycles.
- R8: `irq_i` in the second cycle cancels the write, clears the flag and holds the PC. `pmem_addr_o` equals `pc_o`, so the load-constant is fetched again and restarts from its first cycle.
- R9: `irq_i` in the first cycle of a load-constant keeps the flag clear. `pmem_addr_o` equals `pc_o` and the PC holds.
- R10: `irq_i` in an ordinary cycle cancels the write and holds the PC, with `pmem_addr_o` equal to `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Word read from program memory |
| src_val_i | input | 8 | Value of the source register |
| cond_ok_i | input | 1 | Condition of the current instruction is met |
| irq_i | input | 1 | Interrupt taken in this cycle |
| pmem_addr_o | output | 8 | Next program memory read address |
| pc_o | output | 8 | Address of the word on `instr_i` |
| opcode_o | output | 4 | Effective opcode for the decoder |
| dst_idx_o | output | 3 | Destination register index |
| dst_we_o | output | 1 | Destination register write enable |
| byte_o | output | 8 | Byte selected from the instruction word |

## Verification
The assertions check on every cycle that the first cycle redirects the address to the source value without a write, and that the busy cycle always carries the move opcode. They also check that the busy cycle never lasts two cycles, that the PC stays frozen into the busy cycle, that an interrupt never coexists with a write, and that a failed-condition load-constant steps the PC. Only the bench scenarios show the choice of byte from real memory contents, the replay of the saved destination against a different live field, and the full re-execution after an interrupt in the second cycle. Those scenarios follow a program through a modelled synchronous memory.

// File: rtl/ldc_sequencer.sv
module ldc_sequencer #(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int OPW = 4,
  parameter int RW = 3,
  parameter logic [3:0] OP_LDC = 4'hC,
  parameter logic [3:0] OP_MOV = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr_i,
  input  logic [DW-1:0] src_val_i,
  input  logic          cond_ok_i,
  input  logic          irq_i,
  output logic [DW-1:0] pmem_addr_o,
  output logic [DW-1:0] pc_o,
  output logic [OPW-1:0] opcode_o,
  output logic [RW-1:0] dst_idx_o,
  output logic          dst_we_o,
  output logic [DW-1:0] byte_o
);
  localparam int OP_LSB  = IW - OPW;
  localparam int SEL_BIT = OP_LSB - 1;
  localparam int DST_LSB = SEL_BIT - RW;

  logic [DW-1:0]  pc_q, pc_next;
  logic           ldc_q, sel_q;
  logic [RW-1:0]  dst_q;
  logic [OPW-1:0] op_live;
  logic           is_ldc, ldc_go, pc_hold;

  assign op_live = instr_i[IW-1 -: OPW];
  assign is_ldc  = !ldc_q && (op_live == OP_LDC[OPW-1:0]);
  assign ldc_go  = is_ldc && cond_ok_i && !irq_i;
  assign pc_hold = irq_i || ldc_go;
  assign pc_next = pc_hold ? pc_q : pc_q + 1'b1;

  assign pmem_addr_o = !rst_n ? '0 : (ldc_go ? src_val_i : pc_next);
  assign pc_o        = pc_q;
  assign opcode_o    = ldc_q ? OP_MOV[OPW-1:0] : op_live;
  assign dst_idx_o   = ldc_q ? dst_q : instr_i[DST_LSB +: RW];
  assign dst_we_o    = rst_n && !irq_i && (ldc_q || (!is_ldc && cond_ok_i));
  assign byte_o      = (ldc_q && sel_q) ? instr_i[IW-1 -: DW] : instr_i[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ldc_q <= 1'b0;
      sel_q <= 1'b0;
      dst_q <= '0;
    end else begin
      pc_q  <= pc_next;
      ldc_q <= ldc_go;
      if (ldc_go) begin
        sel_q <= instr_i[SEL_BIT];
        dst_q <= instr_i[DST_LSB +: RW];
      end
    end
  end
endmodule

// File: rtl/ldc_sequencer_chk.sv
module ldc_sequencer_chk #(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int OPW = 4,
  parameter int RW = 3,
  parameter logic [3:0] OP_LDC = 4'hC,
  parameter logic [3:0] OP_MOV = 4'h1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [IW-1:0]  instr_i,
  input logic [DW-1:0]  src_val_i,
  input logic           cond_ok_i,
  input logic           irq_i,
  input logic [DW-1:0]  pmem_addr_o,
  input logic [DW-1:0]  pc_o,
  input logic [OPW-1:0] opcode_o,
  input logic [RW-1:0]  dst_idx_o,
  input logic           dst_we_o,
  input logic [DW-1:0]  byte_o,
  input logic           ldc_q
);
  logic live_ldc;
  assign live_ldc = !ldc_q && (instr_i[IW-1 -: OPW] == OP_LDC[OPW-1:0]);

  AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> (pc_o == '0 && !ldc_q)); // R1
  AST_FIRST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_ldc && cond_ok_i && !irq_i) |-> (pmem_addr_o == src_val_i && !dst_we_o)); // R3
  AST_BUSY_MOV: assert property (@(posedge clk) disable iff (!rst_n)
    ldc_q |-> (opcode_o == OP_MOV[OPW-1:0])); // R5
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ldc_q |=> !ldc_q); // R7
  AST_BUSY_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ldc_q |-> (pc_o == $past(pc_o))); // R3
  AST_IRQ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> (!dst_we_o && pmem_addr_o == pc_o)); // R8
  AST_NOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_ldc && !cond_ok_i && !irq_i) |=> (!ldc_q && pc_o == $past(pc_o) + 1'b1)); // R6
  AST_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ldc_q |-> (byte_o == instr_i[DW-1:0])); // R4
endmodule

bind ldc_sequencer ldc_sequencer_chk #(
  .DW(DW), .IW(IW), .OPW(OPW), .RW(RW), .OP_LDC(OP_LDC), .OP_MOV(OP_MOV)
) u_chk (.*);

// File: tb/sim_ldc_sequencer.sv
`timescale 1ns/1ps
module sim_ldc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i;
  logic [7:0]  src_val_i = '0;
  logic        cond_ok_i = 1'b1;
  logic        irq_i = 1'b0;
  logic [7:0]  pmem_addr_o, pc_o, byte_o;
  logic [3:0]  opcode_o;
  logic [2:0]  dst_idx_o;
  logic        dst_we_o;

  logic [15:0] mem [256];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) instr_i <= mem[pmem_addr_o];

  ldc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .src_val_i(src_val_i),
    .cond_ok_i(cond_ok_i), .irq_i(irq_i), .pmem_addr_o(pmem_addr_o), .pc_o(pc_o),
    .opcode_o(opcode_o), .dst_idx_o(dst_idx_o), .dst_we_o(dst_we_o), .byte_o(byte_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(logic [3:0] op, logic sel, logic [2:0] dst, logic [7:0] lo);
    return {op, sel, dst, lo};
  endfunction

  task automatic restart();
    rst_n = 1'b0;
    cond_ok_i = 1'b1;
    irq_i = 1'b0;
    src_val_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = word(4'h0, 1'b0, 3'd0, i[7:0]);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 addr in reset", pmem_addr_o, 0);
    check("R1 we in reset", dst_we_o, 0);
    check("R1 pc in reset", pc_o, 0);
  endtask

  task automatic t_plain();
    clear_mem();
    for (int i = 0; i < 4; i++) mem[i] = word(4'h2, 1'b1, 3'(i + 1), 8'h10 + 8'(i));
    restart();
    for (int i = 0; i < 4; i++) begin
      cond_ok_i = (i != 2);
      #0.5;
      check("R2 pc", pc_o, i);
      check("R2 opcode", opcode_o, 2);
      check("R2 dst", dst_idx_o, i + 1);
      check("R2 we follows cond", dst_we_o, (i != 2));
      check("R2 addr", pmem_addr_o, i + 1);
      check("R4 idle byte low", byte_o, 8'h10 + i);
      next_cycle();
    end
  endtask

  task automatic t_ldc(logic sel, logic [7:0] exp_byte);
    clear_mem();
    mem[0] = word(4'hC, sel, 3'd5, 8'h00);
    mem[1] = word(4'h2, 1'b0, 3'd2, 8'h00);
    mem[8'h40] = 16'hA53C;
    restart();
    src_val_i = 8'h40;
    #0.5;
    check("R3 addr from src", pmem_addr_o, 8'h40);
    check("R3 no write first", dst_we_o, 0);
    next_cycle();
    cond_ok_i = 1'b0;
    src_val_i = 8'h77;
    #0.5;
    check("R3 pc held", pc_o, 0);
    check("R4 byte", byte_o, exp_byte);
    check("R5 mov opcode", opcode_o, 1);
    check("R5 saved dst", dst_idx_o, 5);
    check("R5 write ignores cond", dst_we_o, 1);
    check("R7 addr back to pc", pmem_addr_o, 1);
    next_cycle();
    cond_ok_i = 1'b1;
    #0.5;
    check("R7 pc after", pc_o, 1);
    check("R7 ordinary again", opcode_o, 2);
    check("R7 live dst", dst_idx_o, 2);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = word(4'hC, 1'b1, 3'd4, 8'h00);
    mem[1] = word(4'h3, 1'b0, 3'd6, 8'h00);
    restart();
    src_val_i = 8'h40;
    cond_ok_i = 1'b0;
    #0.5;
    check("R6 no write", dst_we_o, 0);
    check("R6 addr", pmem_addr_o, 1);
    next_cycle();
    cond_ok_i = 1'b1;
    #0.5;
    check("R6 pc stepped", pc_o, 1);
    check("R6 next ordinary", opcode_o, 3);
    check("R6 next dst live", dst_idx_o, 6);
  endtask

  task automatic t_irq_second();
    clear_mem();
    mem[0] = word(4'hC, 1'b0, 3'd3, 8'h00);
    mem[8'h50] = 16'h1299;
    restart();
    src_val_i = 8'h50;
    next_cycle();
    irq_i = 1'b1;
    #0.5;
    check("R8 write cancelled", dst_we_o, 0);
    check("R8 addr refetch", pmem_addr_o, 0);
    next_cycle();
    irq_i = 1'b0;
    #0.5;
    check("R8 pc held", pc_o, 0);
    check("R8 refetched ldc", opcode_o, 4'hC);
    check("R8 restart redirect", pmem_addr_o, 8'h50);
    next_cycle();
    #0.5;
    check("R8 completes write", dst_we_o, 1);
    check("R8 completes byte", byte_o, 8'h99);
    check("R8 completes dst", dst_idx_o, 3);
  endtask

  task automatic t_irq_first();
    clear_mem();
    mem[0] = word(4'hC, 1'b1, 3'd1, 8'h00);
    restart();
    src_val_i = 8'h30;
    irq_i = 1'b1;
    #0.5;
    check("R9 addr is pc", pmem_addr_o, 0);
    check("R9 no write", dst_we_o, 0);
    next_cycle();
    irq_i = 1'b0;
    #0.5;
    check("R9 pc held", pc_o, 0);
    check("R9 flag stayed clear", opcode_o, 4'hC);
  endtask

  task automatic t_irq_plain();
    clear_mem();
    mem[0] = word(4'h2, 1'b0, 3'd7, 8'h00);
    restart();
    irq_i = 1'b1;
    #0.5;
    check("R10 no write", dst_we_o, 0);
    check("R10 addr is pc", pmem_addr_o, 0);
    next_cycle();
    irq_i = 1'b0;
    #0.5;
    check("R10 pc held", pc_o, 0);
    check("R10 write resumes", dst_we_o, 1);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_ldc(1'b1, 8'hA5);
    t_ldc(1'b0, 8'h3C);
    t_nop();
    t_irq_second();
    t_irq_first();
    t_irq_plain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule